// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block carries data between two buses, A and B, in two independent directions. A-to-B and B-to-A each have their own storage cell in front of a three-state output driver. Each cycle, a latch-enable level puts the storage cell into one of three roles. It can be a transparent latch that passes the input straight through. It can be a holding latch. It can be an edge-triggered register that loads on a rising edge of its own data clock, gated by an active-low clock enable. Data passes without inversion. An active-low output enable decides whether a direction drives its far bus. When it does not drive, the direction's drive-enable is low, which stands for the high-impedance state.

All control inputs are sampled on one system clock that has an asynchronous active-low reset. The data clock of each direction is a plain input: a rising edge is seen when one sample is low and the next sample is high. Each data input has a per-bit "driven" qualifier. A bit that is not driven keeps the last valid level seen on it, which models a bus keeper. A conflict flag is raised whenever both directions drive at the same time.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: While a direction's latch enable is 1, its output data equals its effective input in the same cycle, without inversion. The default data width is 18 bits.
- R2: While the latch enable is 0 and no load is taken, the output data keeps its previous value, even when the input changes.
- R3: With the latch enable at 0, a data-clock sample of 1 that follows a sample of 0 loads the effective input into storage when the clock enable (active low) is 0 at that same sample. The output shows the loaded value from the next cycle on.
- R4: A data-clock rising edge taken while the clock enable is 1 leaves storage unchanged.
- R5: A data clock held at 1 over several samples loads only once, on the sample where it first rises.
- R6: When the latch enable falls, storage holds the last transparently passed value, whether the data clock is 0 or 1 at that moment.
- R7: A direction's drive-enable is 1 exactly when its active-low output enable is 0 and reset is not asserted. The output data is valid whether or not the direction drives.
- R8: While reset is asserted, both drive-enables are 0. After reset, both storage cells and both bus keepers hold all zeros.
- R9: A data bit whose driven qualifier is 0 takes, as its effective input, the effective level of that bit in the previous cycle (zero after reset). A bit whose qualifier is 1 takes the input pin.
- R10: The conflict flag is 1 exactly when both drive-enables are 1.
- R11: The two directions are independent: no control or data input of one direction affects the other direction's output data or drive-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | A-bus data seen by the A-to-B direction |
| a_in_vld | input | W | Per-bit driven qualifier for a_in (1 = driven) |
| b_in | input | W | B-bus data seen by the B-to-A direction |
| b_in_vld | input | W | Per-bit driven qualifier for b_in (1 = driven) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_dclk | input | 1 | A-to-B data clock, loads on a rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_dclk | input | 1 | B-to-A data clock, loads on a rising edge |
| b_out | output | W | Data driven onto the B bus |
| b_out_en | output | 1 | B-bus drive-enable (0 = high impedance) |
| a_out | output | W | Data driven onto the A bus |
| a_out_en | output | 1 | A-bus drive-enable (0 = high impedance) |
| conflict_o | output | 1 | Both directions driving at once |

## Verification
Transparent passing is tried with changing words to show that the output follows the input with no stored delay. Latch-enable falls with the data clock at 0 and at 1 show that the captured word is the last one passed, and not the word present at a later clock edge. Edge loads are tried with the clock enable at 0 and at 1, and with the data clock held high while the input changes, which separates true rising-edge loading from level loading. Partial driven masks show the keeper retaining undriven bits while driven bits pass. A long random phase drives both directions at once against a behavioural model, to show they stay separate and to exercise the conflict flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // role of a storage cell in one cycle
  typedef enum logic [1:0] {
    CELL_HOLD = 2'd0,
    CELL_PASS = 2'd1,
    CELL_LOAD = 2'd2
  } cell_mode_e;

  // latch enable dominates; an accepted edge only matters when opaque
  function automatic cell_mode_e pick_mode(input logic le, input logic load);
    if (le)        return CELL_PASS;
    else if (load) return CELL_LOAD;
    else           return CELL_HOLD;
  endfunction

  // rising edge seen between two consecutive samples
  function automatic logic rose_between(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] pin_vld,
  output logic [W-1:0] level_o
);

  logic [W-1:0] kept_q;

  // driven bits come from the pin, floating bits from the keeper
  function automatic logic [W-1:0] keep_merge(input logic [W-1:0] p,
                                              input logic [W-1:0] v,
                                              input logic [W-1:0] k);
    return (p & v) | (k & ~v);
  endfunction

  assign level_o = keep_merge(pin, pin_vld, kept_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kept_q <= '0;
    else        kept_q <= level_o;
  end

endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         ce_n,
  input  logic         dclk,
  output logic [W-1:0] q_o,
  output logic         load_o
);

  logic         dclk_q;
  logic [W-1:0] store_q;
  logic         edge_seen;
  cell_mode_e   mode;

  assign edge_seen = rose_between(dclk_q, dclk);
  assign load_o    = ~le & edge_seen & ~ce_n;
  assign mode      = pick_mode(le, load_o);

  // transparent path bypasses storage in the same cycle
  assign q_o = le ? d : store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else begin
      case (mode)
        CELL_PASS: store_q <= d;
        CELL_LOAD: store_q <= d;
        default:   store_q <= store_q;
      endcase
    end
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] din_vld,
  input  logic         oe_n,
  input  logic         le,
  input  logic         ce_n,
  input  logic         dclk,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic [W-1:0] eff_o,
  output logic         load_o
);

  logic [W-1:0] level;
  logic [W-1:0] cell_q;

  xcvr_bus_keeper #(.W(W)) u_keep (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (din),
    .pin_vld (din_vld),
    .level_o (level)
  );

  xcvr_store_cell #(.W(W)) u_cell (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (level),
    .le     (le),
    .ce_n   (ce_n),
    .dclk   (dclk),
    .q_o    (cell_q),
    .load_o (load_o)
  );

  // three-state driver: data always present, enable gates the bus
  assign dout    = cell_q;
  assign dout_en = rst_n & ~oe_n;
  assign eff_o   = level;

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_in_vld,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_in_vld,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_ce_n,
  input  logic         ab_dclk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ce_n,
  input  logic         ba_dclk,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  output logic [W-1:0] a_out,
  output logic         a_out_en,
  output logic         conflict_o
);

  // internal events brought out for the checker
  logic [W-1:0] ab_eff;
  logic [W-1:0] ba_eff;
  logic         ab_load;
  logic         ba_load;

  xcvr_lane #(.W(W)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (a_in),
    .din_vld (a_in_vld),
    .oe_n    (ab_oe_n),
    .le      (ab_le),
    .ce_n    (ab_ce_n),
    .dclk    (ab_dclk),
    .dout    (b_out),
    .dout_en (b_out_en),
    .eff_o   (ab_eff),
    .load_o  (ab_load)
  );

  xcvr_lane #(.W(W)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (b_in),
    .din_vld (b_in_vld),
    .oe_n    (ba_oe_n),
    .le      (ba_le),
    .ce_n    (ba_ce_n),
    .dclk    (ba_dclk),
    .dout    (a_out),
    .dout_en (a_out_en),
    .eff_o   (ba_eff),
    .load_o  (ba_load)
  );

  assign conflict_o = a_out_en & b_out_en;

endmodule

// File: rtl/xcvr_checks.sv
module xcvr_checks #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ab_le,
  input logic         ab_oe_n,
  input logic         ba_le,
  input logic         ba_oe_n,
  input logic [W-1:0] a_in_vld,
  input logic [W-1:0] ab_eff,
  input logic [W-1:0] ba_eff,
  input logic         ab_load,
  input logic         ba_load,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_out_en,
  input logic         b_out_en,
  input logic         conflict_o
);

  // set once a full edge has passed out of reset, so $past is post-reset
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_pass_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> b_out == ab_eff);
  assert_pass_ba_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |-> a_out == ba_eff);

  assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (!ab_le && !ab_load) |=> (ab_le || b_out == $past(b_out)));
  assert_hold_ba_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (!ba_le && !ba_load) |=> (ba_le || a_out == $past(a_out)));

  assert_load_ab_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ab_load |=> (ab_le || b_out == $past(ab_eff)));

  assert_fall_ab_R6: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $fell(ab_le) |-> b_out == $past(b_out));

  assert_oe_ab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> !b_out_en);
  assert_oe_ba_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> !a_out_en);

  assert_rst_hiz_R8: assert property (@(posedge clk)
    !rst_n |-> (!a_out_en && !b_out_en));

  assert_keeper_R9: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ((ab_eff ^ $past(ab_eff)) & ~a_in_vld) == '0);

  assert_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> (!ab_oe_n && !ba_oe_n));

endmodule

bind bidir_reg_xcvr xcvr_checks #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ab_le      (ab_le),
  .ab_oe_n    (ab_oe_n),
  .ba_le      (ba_le),
  .ba_oe_n    (ba_oe_n),
  .a_in_vld   (a_in_vld),
  .ab_eff     (ab_eff),
  .ba_eff     (ba_eff),
  .ab_load    (ab_load),
  .ba_load    (ba_load),
  .a_out      (a_out),
  .b_out      (b_out),
  .a_out_en   (a_out_en),
  .b_out_en   (b_out_en),
  .conflict_o (conflict_o)
);

// File: tb/bidir_reg_xcvr_bench.sv
module bidir_reg_xcvr_bench;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, a_in_vld = '1, b_in = '0, b_in_vld = '1;
  logic         ab_oe_n = 1'b1, ab_le = 1'b0, ab_ce_n = 1'b1, ab_dclk = 1'b0;
  logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_ce_n = 1'b1, ba_dclk = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic         b_out_en, a_out_en, conflict_o;

  always #10 clk = ~clk;

  bidir_reg_xcvr #(.W(W)) u_bidir_reg_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ce_n(ab_ce_n), .ab_dclk(ab_dclk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ce_n(ba_ce_n), .ba_dclk(ba_dclk),
    .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en),
    .conflict_o(conflict_o)
  );

  // behavioural reference: index 0 = A-to-B, 1 = B-to-A
  logic [W-1:0] m_keep [2];
  logic [W-1:0] m_store [2];
  bit           m_prev [2];
  int           n_vec = 0;
  int           n_bad = 0;
  bit           done = 0;

  function automatic logic [W-1:0] eff_of(int d);
    logic [W-1:0] p, v;
    p = (d == 0) ? a_in : b_in;
    v = (d == 0) ? a_in_vld : b_in_vld;
    eff_of = '0;
    for (int i = 0; i < W; i++) eff_of[i] = v[i] ? p[i] : m_keep[d][i];
  endfunction

  function automatic logic [W-1:0] exp_out(int d);
    logic le;
    le = (d == 0) ? ab_le : ba_le;
    return le ? eff_of(d) : m_store[d];
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_keep[d] = '0; m_store[d] = '0; m_prev[d] = 0;
    end
  endtask

  task automatic model_tick();
    logic [W-1:0] e [2];
    logic le, ce_n, dc;
    for (int d = 0; d < 2; d++) e[d] = eff_of(d);
    for (int d = 0; d < 2; d++) begin
      le   = (d == 0) ? ab_le : ba_le;
      ce_n = (d == 0) ? ab_ce_n : ba_ce_n;
      dc   = (d == 0) ? ab_dclk : ba_dclk;
      if (le) m_store[d] = e[d];
      else if (dc && !m_prev[d] && !ce_n) m_store[d] = e[d];
      m_keep[d] = e[d];
      m_prev[d] = dc;
    end
  endtask

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // called just after a falling edge with inputs set; ends after the next falling edge
  task automatic step(string tag);
    logic e_ben, e_aen;
    #2;
    e_ben = rst_n && !ab_oe_n;
    e_aen = rst_n && !ba_oe_n;
    chk(tag, "b_out_en", {{(W-1){1'b0}}, b_out_en}, {{(W-1){1'b0}}, e_ben});
    chk(tag, "a_out_en", {{(W-1){1'b0}}, a_out_en}, {{(W-1){1'b0}}, e_aen});
    chk(tag, "conflict", {{(W-1){1'b0}}, conflict_o}, {{(W-1){1'b0}}, e_ben && e_aen});
    if (rst_n) begin
      chk(tag, "b_out", b_out, exp_out(0));
      chk(tag, "a_out", a_out, exp_out(1));
    end
    @(posedge clk);
    if (rst_n) model_tick(); else model_reset();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    // R8: drivers off during reset even with enables asserted
    ab_oe_n = 0; ba_oe_n = 0; ab_le = 1; a_in = 18'h2AAAA;
    step("R8"); step("R8");
    rst_n = 1; ab_le = 0; ba_le = 0;
    step("R8"); // storage reads back zero, drivers on

    // R1: transparent pass, several words
    ab_le = 1;
    a_in = 18'h3FFFF; step("R1");
    a_in = 18'h00001; step("R1");
    a_in = 18'h15A5A; step("R1");

    // R6: fall of latch enable with data clock low
    a_in = 18'h0C3C3; step("R6");
    ab_le = 0; a_in = 18'h3F000; step("R6");
    step("R6");
    // R6: fall with data clock high
    ab_le = 1; ab_dclk = 1; ab_ce_n = 0; a_in = 18'h12345; step("R6");
    ab_le = 0; a_in = 18'h2EEEE; step("R6");
    step("R6");

    // R2: opaque, clock steady, input changing
    ab_dclk = 0; ab_ce_n = 1;
    for (int i = 0; i < 4; i++) begin a_in = 18'h01111 * (i + 1); step("R2"); end

    // R3: rising edge with enable low loads
    ab_ce_n = 0; a_in = 18'h0BEEF; step("R3");
    ab_dclk = 1; step("R3");
    a_in = 18'h00F0F; step("R3");
    // R5: clock held high, input changing, no further load
    for (int i = 0; i < 4; i++) begin a_in = 18'h20000 + 18'(i); step("R5"); end
    // R4: edge blocked by clock enable high
    ab_dclk = 0; step("R4");
    ab_ce_n = 1; ab_dclk = 1; a_in = 18'h3C3C3; step("R4");
    step("R4");

    // R9: partially driven input in transparent mode
    ab_le = 1; ab_dclk = 0; a_in = 18'h3FFFF; a_in_vld = '1; step("R9");
    a_in = 18'h00000; a_in_vld = 18'h000FF; step("R9");
    a_in = 18'h3FFFF; a_in_vld = 18'h3FF00; step("R9");
    a_in_vld = '0; a_in = 18'h0; step("R9");
    a_in_vld = '1;

    // R7 and R10: output-enable combinations
    ab_oe_n = 1; ba_oe_n = 1; step("R7");
    ab_oe_n = 0; ba_oe_n = 1; step("R10");
    ab_oe_n = 1; ba_oe_n = 0; step("R10");
    ab_oe_n = 0; ba_oe_n = 0; step("R10");

    // R11: both directions randomised together
    for (int i = 0; i < 600; i++) begin
      a_in = 18'($urandom); b_in = 18'($urandom);
      a_in_vld = ($urandom_range(0, 3) == 0) ? 18'($urandom) : '1;
      b_in_vld = ($urandom_range(0, 3) == 0) ? 18'($urandom) : '1;
      ab_oe_n = 1'($urandom); ab_le = ($urandom_range(0, 3) == 0);
      ab_ce_n = 1'($urandom); ab_dclk = 1'($urandom);
      ba_oe_n = 1'($urandom); ba_le = ($urandom_range(0, 3) == 0);
      ba_ce_n = 1'($urandom); ba_dclk = 1'($urandom);
      step("R11");
    end

    // R8: reset again mid-run
    rst_n = 0; ab_oe_n = 0; ba_oe_n = 0; step("R8");
    rst_n = 1; ab_le = 0; ba_le = 0; a_in_vld = '0; b_in_vld = '0; step("R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule